// File: doc/BRIEF.md
# Counter-Mode Block Chaining Controller

This block sits between software-facing configuration and an external block-cipher engine and runs counter-mode chaining over 128-bit blocks. It keeps a small control word (a run bit, a chaining selector and a direction selector) and a 128-bit initialization vector. The vector is split into a fixed nonce in its upper bits and a running counter in its lowest 32 bits. Each time the run bit is set with a legal counter-mode setting, the controller hands the current vector to the engine, captures the returned keystream, and waits for one input block. It XORs the input with the keystream, presents the result for one cycle, steps the counter and drops the run bit by itself.

Encryption and decryption are the same operation here, because the engine only ever encrypts the counter block. A short final block is handled by giving its significant byte count. Bytes past that count are treated as zero on the way in and are forced to zero on the way out. A message can be suspended by reading the vector, which always holds the counter for the next block, and resumed later by writing that value back while the controller is idle.

Top module: `ctr_chain_ctl`

## Requirements
- R1: A control write with `cfg_en`=1 starts a block only when `cfg_chain` is 3'b010 and `cfg_mode` is not 2'b01; otherwise `run_o` stays 0 and no engine start is issued.
- R2: One cycle after a block starts, `eng_start` pulses once and `eng_blk` carries the vector as it stood when the block started.
- R3: `dout` equals the input XOR the keystream returned for the current counter block, with the same result for every accepted mode value (2'b00, 2'b10, 2'b11), so feeding back a ciphertext under the same vector restores the plaintext.
- R4: After each block the low 32 bits of the vector increase by one modulo 2^32 and the upper 96 bits are unchanged, with no carry from 32'hFFFFFFFF into them.
- R5: `dout_valid` is high for exactly one cycle per block, on the cycle after the input is accepted, and `run_o` is 0 in that same cycle.
- R6: While `run_o` is 1, control writes and vector writes have no effect on the vector, the settings or the error flag.
- R7: A control write with chain 3'b010 and mode 2'b01 sets `cfg_err`. The flag stays set until reset, and that write starts nothing.
- R8: `din_len` gives the number of significant bytes, with byte 0 in bits [127:120]. Input bytes with index at or above `din_len` are treated as zero, and the same output bytes read as zero. Values of 16 or more mean a full block.
- R9: `iv_rd` always shows the vector for the next block. Writing a saved value back while idle makes the next block use that counter.
- R10: `din_ready` is 1 only after the keystream has returned and before the block's input is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_en | input | 1 | Run bit value written with the control word |
| cfg_chain | input | 3 | Chaining selector; 3'b010 is counter mode |
| cfg_mode | input | 2 | Direction selector; 2'b01 is forbidden in counter mode |
| iv_we | input | 1 | Vector write strobe |
| iv_wdata | input | 128 | Vector write data |
| run_o | output | 1 | Run bit; cleared by hardware when a block completes |
| cfg_err | output | 1 | Sticky illegal-configuration flag |
| iv_rd | output | 128 | Current vector (next counter block) |
| eng_start | output | 1 | One-cycle start request to the cipher engine |
| eng_blk | output | 128 | Counter block sent to the engine |
| eng_done | input | 1 | Engine completion pulse |
| eng_ks | input | 128 | Keystream from the engine, valid with `eng_done` |
| din_valid | input | 1 | Input block offered |
| din_ready | output | 1 | Controller can take an input block |
| din | input | 128 | Input block (plaintext or ciphertext) |
| din_len | input | 5 | Significant byte count of the input block |
| dout_valid | output | 1 | Result valid pulse, marks block done |
| dout | output | 128 | Result block |

## Verification
A stuck or mis-stepped counter shows on `iv_rd` the cycle after the block's output pulse, and from the next block on it shows as a wrong keystream in `dout`. A carry leaking into the nonce only shows once the counter crosses 32'hFFFFFFFF, so the sweeps start just below that point. A phase register left in the wrong state shows as a missing `eng_start`, a `din_ready` raised before the keystream is back, or `run_o` not falling. All of these appear within the same block.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_KEY  = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

endpackage

// File: rtl/ctr_iv_step.sv
module ctr_iv_step #(
    parameter int BLK_W = 128,
    parameter int CNT_W = 32
) (
    input  logic [BLK_W-1:0] iv_cur,
    output logic [BLK_W-1:0] iv_nxt
);
    localparam int NONCE_W = BLK_W - CNT_W;

    logic [CNT_W-1:0]   cnt_cur;
    logic [CNT_W-1:0]   cnt_inc;
    logic [NONCE_W-1:0] nonce;

    always_comb begin
        cnt_cur = iv_cur[CNT_W-1:0];
        nonce   = iv_cur[BLK_W-1:CNT_W];
        // counter wraps in its own width; nonce is passed through untouched
        cnt_inc = cnt_cur + {{(CNT_W-1){1'b0}}, 1'b1};
        iv_nxt  = {nonce, cnt_inc};
    end

endmodule

// File: rtl/ctr_byte_mask.sv
module ctr_byte_mask #(
    parameter int BLK_W = 128,
    parameter int LEN_W = 5
) (
    input  logic [LEN_W-1:0] len,
    output logic [BLK_W-1:0] mask
);
    localparam int NBYTES = BLK_W / 8;

    // byte 0 is the most significant byte of the block
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        localparam logic [LEN_W-1:0] IDX = LEN_W'(i);
        assign mask[BLK_W-1-8*i -: 8] = {8{len > IDX}};
    end

endmodule

// File: rtl/ctr_ks_mix.sv
module ctr_ks_mix #(
    parameter int BLK_W = 128,
    parameter int LEN_W = 5
) (
    input  logic [BLK_W-1:0] data_in,
    input  logic [BLK_W-1:0] keystream,
    input  logic [LEN_W-1:0] len,
    output logic [BLK_W-1:0] data_out
);
    logic [BLK_W-1:0] keep;
    logic [BLK_W-1:0] padded;

    ctr_byte_mask #(
        .BLK_W(BLK_W),
        .LEN_W(LEN_W)
    ) i_mask (
        .len (len),
        .mask(keep)
    );

    always_comb begin
        padded   = data_in & keep;
        data_out = (padded ^ keystream) & keep;
    end

endmodule

// File: rtl/ctr_chain_ctl.sv
module ctr_chain_ctl
    import ctr_pkg::*;
#(
    parameter int               BLK_W     = 128,
    parameter int               CNT_W     = 32,
    parameter int               CHAIN_W   = 3,
    parameter int               MODE_W    = 2,
    parameter logic [CHAIN_W-1:0] CHAIN_CTR = 3'b010,
    parameter logic [MODE_W-1:0]  MODE_KD   = 2'b01,
    localparam int              NBYTES    = BLK_W / 8,
    localparam int              LEN_W     = $clog2(NBYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_en,
    input  logic [CHAIN_W-1:0] cfg_chain,
    input  logic [MODE_W-1:0]  cfg_mode,
    input  logic               iv_we,
    input  logic [BLK_W-1:0]   iv_wdata,
    output logic               run_o,
    output logic               cfg_err,
    output logic [BLK_W-1:0]   iv_rd,
    output logic               eng_start,
    output logic [BLK_W-1:0]   eng_blk,
    input  logic               eng_done,
    input  logic [BLK_W-1:0]   eng_ks,
    input  logic               din_valid,
    output logic               din_ready,
    input  logic [BLK_W-1:0]   din,
    input  logic [LEN_W-1:0]   din_len,
    output logic               dout_valid,
    output logic [BLK_W-1:0]   dout
);

    typedef struct packed {
        phase_e             ph;
        logic               run;
        logic [CHAIN_W-1:0] chain;
        logic [MODE_W-1:0]  mode;
        logic               err;
        logic               start;
        logic [BLK_W-1:0]   iv;
        logic [BLK_W-1:0]   ks;
        logic               ovld;
        logic [BLK_W-1:0]   odata;
    } state_t;

    state_t s_d, s_q;

    logic [BLK_W-1:0] iv_next;
    logic [BLK_W-1:0] mixed;
    logic             wr_is_ctr;
    logic             wr_is_kd;
    logic             wr_launch;

    ctr_iv_step #(
        .BLK_W(BLK_W),
        .CNT_W(CNT_W)
    ) i_step (
        .iv_cur(s_q.iv),
        .iv_nxt(iv_next)
    );

    ctr_ks_mix #(
        .BLK_W(BLK_W),
        .LEN_W(LEN_W)
    ) i_mix (
        .data_in  (din),
        .keystream(s_q.ks),
        .len      (din_len),
        .data_out (mixed)
    );

    // decode of the incoming control word
    always_comb begin
        wr_is_ctr = (cfg_chain == CHAIN_CTR);
        wr_is_kd  = (cfg_mode == MODE_KD);
        wr_launch = cfg_en && wr_is_ctr && !wr_is_kd;
    end

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        s_d.ovld  = 1'b0;

        unique case (s_q.ph)
            PH_IDLE: begin
                if (iv_we) begin
                    s_d.iv = iv_wdata;
                end
                if (cfg_we) begin
                    s_d.chain = cfg_chain;
                    s_d.mode  = cfg_mode;
                    if (wr_is_ctr && wr_is_kd) begin
                        s_d.err = 1'b1;
                    end
                    if (wr_launch) begin
                        s_d.run   = 1'b1;
                        s_d.start = 1'b1;
                        s_d.ph    = PH_KEY;
                    end
                end
            end
            PH_KEY: begin
                if (eng_done) begin
                    s_d.ks = eng_ks;
                    s_d.ph = PH_DATA;
                end
            end
            PH_DATA: begin
                if (din_valid) begin
                    s_d.odata = mixed;
                    s_d.ovld  = 1'b1;
                    s_d.iv    = iv_next;
                    s_d.run   = 1'b0;
                    s_d.ph    = PH_IDLE;
                end
            end
            default: begin
                s_d.ph  = PH_IDLE;
                s_d.run = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{
                ph:    PH_IDLE,
                run:   1'b0,
                chain: '0,
                mode:  '0,
                err:   1'b0,
                start: 1'b0,
                iv:    '0,
                ks:    '0,
                ovld:  1'b0,
                odata: '0
            };
        end else begin
            s_q <= s_d;
        end
    end

    assign run_o      = s_q.run;
    assign cfg_err    = s_q.err;
    assign iv_rd      = s_q.iv;
    assign eng_start  = s_q.start;
    assign eng_blk    = s_q.iv;
    assign din_ready  = (s_q.ph == PH_DATA);
    assign dout_valid = s_q.ovld;
    assign dout       = s_q.odata;

endmodule

// File: rtl/ctr_chain_chk.sv
module ctr_chain_chk #(
    parameter int BLK_W = 128,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_o,
    input logic             cfg_err,
    input logic [BLK_W-1:0] iv_rd,
    input logic             eng_start,
    input logic             din_ready,
    input logic             dout_valid
);

    a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |=> !dout_valid);

    a_r5_run_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> !run_o);

    a_r4_nonce_kept: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> (iv_rd[BLK_W-1:CNT_W] == $past(iv_rd[BLK_W-1:CNT_W])));

    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> (iv_rd[CNT_W-1:0] ==
                        CNT_W'($past(iv_rd[CNT_W-1:0]) + {{(CNT_W-1){1'b0}}, 1'b1})));

    a_r6_iv_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && $past(run_o)) |-> $stable(iv_rd));

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_err) |-> cfg_err);

    a_r10_ready_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        din_ready |-> run_o);

    a_r2_start_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (run_o && !din_ready));

endmodule

bind ctr_chain_ctl ctr_chain_chk #(
    .BLK_W(BLK_W),
    .CNT_W(CNT_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_o     (run_o),
    .cfg_err   (cfg_err),
    .iv_rd     (iv_rd),
    .eng_start (eng_start),
    .din_ready (din_ready),
    .dout_valid(dout_valid)
);

// File: tb/test_ctr_chain_ctl.sv
module test_ctr_chain_ctl;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic         cfg_en = 1'b0;
    logic [2:0]   cfg_chain = 3'b000;
    logic [1:0]   cfg_mode = 2'b00;
    logic         iv_we = 1'b0;
    logic [127:0] iv_wdata = '0;
    logic         run_o;
    logic         cfg_err;
    logic [127:0] iv_rd;
    logic         eng_start;
    logic [127:0] eng_blk;
    logic         eng_done = 1'b0;
    logic [127:0] eng_ks = '0;
    logic         din_valid = 1'b0;
    logic         din_ready;
    logic [127:0] din = '0;
    logic [4:0]   din_len = 5'd16;
    logic         dout_valid;
    logic [127:0] dout;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    int           starts = 0;
    logic [127:0] blk_seen = '0;
    logic [127:0] held = '0;
    int           lat = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctr_chain_ctl i_ctr_chain_ctl (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_chain(cfg_chain), .cfg_mode(cfg_mode),
        .iv_we(iv_we), .iv_wdata(iv_wdata),
        .run_o(run_o), .cfg_err(cfg_err), .iv_rd(iv_rd),
        .eng_start(eng_start), .eng_blk(eng_blk), .eng_done(eng_done), .eng_ks(eng_ks),
        .din_valid(din_valid), .din_ready(din_ready), .din(din), .din_len(din_len),
        .dout_valid(dout_valid), .dout(dout)
    );

    function automatic logic [127:0] perm(input logic [127:0] b);
        return {b[114:0], b[127:115]} ^ (b >> 7) ^ {4{32'h9E3779B9}};
    endfunction

    function automatic logic [127:0] expect_out(input logic [127:0] iv,
                                                input logic [127:0] data,
                                                input int len);
        logic [127:0] m = '0;
        for (int i = 0; i < 16; i++) if (i < len) m[127-8*i -: 8] = 8'hFF;
        return ((data & m) ^ perm(iv)) & m;
    endfunction

    function automatic logic [127:0] step(input logic [127:0] iv);
        return {iv[127:32], iv[31:0] + 32'd1};
    endfunction

    // stand-in cipher engine: fixed latency, deterministic permutation
    always @(posedge clk) begin
        eng_done <= 1'b0;
        if (eng_start) begin
            held     <= eng_blk;
            blk_seen <= eng_blk;
            starts   <= starts + 1;
            lat      <= 3;
        end else if (lat > 0) begin
            lat <= lat - 1;
            if (lat == 1) begin
                eng_done <= 1'b1;
                eng_ks   <= perm(held);
            end
        end
    end

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic write_iv(input logic [127:0] v);
        @(negedge clk);
        iv_we = 1'b1; iv_wdata = v;
        @(negedge clk);
        iv_we = 1'b0;
    endtask

    task automatic write_cfg(input logic en, input logic [2:0] ch, input logic [1:0] md);
        @(negedge clk);
        cfg_we = 1'b1; cfg_en = en; cfg_chain = ch; cfg_mode = md;
        @(negedge clk);
        cfg_we = 1'b0; cfg_en = 1'b0;
    endtask

    task automatic start_blk(input logic [1:0] md);
        write_cfg(1'b1, 3'b010, md);
        chk("R1 run set", 128'(run_o), 128'(1'b1));
        chk("R10 not ready before keystream", 128'(din_ready), 128'(1'b0));
    endtask

    task automatic feed(input logic [127:0] data, input int len, output logic [127:0] res);
        while (!din_ready) @(negedge clk);
        din_valid = 1'b1; din = data; din_len = 5'(len);
        @(negedge clk);
        din_valid = 1'b0;
        chk("R5 valid pulse", 128'(dout_valid), 128'(1'b1));
        chk("R5 run cleared", 128'(run_o), 128'(1'b0));
        res = dout;
        @(negedge clk);
        chk("R5 valid one cycle", 128'(dout_valid), 128'(1'b0));
    endtask

    task automatic run_block(input logic [127:0] iv_exp, input logic [1:0] md,
                             input logic [127:0] data, input int len,
                             output logic [127:0] res);
        int s0 = starts;
        start_blk(md);
        feed(data, len, res);
        chk("R2 one start", 128'(starts - s0), 128'(1));
        chk("R2 engine block", blk_seen, iv_exp);
        chk("R3 R8 output", res, expect_out(iv_exp, data, len));
        chk("R4 counter step", iv_rd, step(iv_exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=hang exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] iv_m;
        logic [127:0] res;
        logic [127:0] ct;
        logic [127:0] saved;
        logic [127:0] pt;
        int s0;

        repeat (3) @(negedge clk);
        chk("R1 reset run", 128'(run_o), 128'(1'b0));
        chk("R7 reset err", 128'(cfg_err), 128'(1'b0));
        chk("R9 reset iv", iv_rd, '0);
        chk("R5 reset valid", 128'(dout_valid), 128'(1'b0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 idle not ready", 128'(din_ready), 128'(1'b0));

        // sweep: lengths 0..16 plus oversize, modes cycle, counter crosses wrap
        iv_m = {96'hA5A5_0123_4567_89AB_CDEF_0F1E, 32'hFFFF_FFF6};
        write_iv(iv_m);
        chk("R9 iv readback", iv_rd, iv_m);
        for (int k = 0; k < 20; k++) begin
            logic [1:0] md = (k % 3 == 0) ? 2'b00 : ((k % 3 == 1) ? 2'b10 : 2'b11);
            logic [127:0] data = {4{32'h1357_9BDF ^ 32'(k * 32'h0101_0101)}};
            int len = (k < 17) ? k : 16 + (k - 16) * 5;
            run_block(iv_m, md, data, len, res);
            iv_m = step(iv_m);
        end
        chk("R4 wrapped nonce kept", iv_rd[127:32], {32'h0, 96'hA5A5_0123_4567_89AB_CDEF_0F1E});

        // decrypt equals encrypt: same vector brings plaintext back
        pt = 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF;
        saved = iv_rd;
        run_block(saved, 2'b00, pt, 16, ct);
        write_iv(saved);
        run_block(saved, 2'b11, ct, 16, res);
        chk("R3 roundtrip", res, pt);

        // suspend: save, run another message, restore and continue
        saved = iv_rd;
        write_iv({96'h0, 32'h0000_0100});
        run_block({96'h0, 32'h0000_0100}, 2'b10, pt, 16, res);
        write_iv(saved);
        chk("R9 restored", iv_rd, saved);
        run_block(saved, 2'b00, ~pt, 11, res);

        // writes while running have no effect
        iv_m = iv_rd;
        start_blk(2'b00);
        cfg_we = 1'b1; cfg_en = 1'b0; cfg_chain = 3'b010; cfg_mode = 2'b01;
        iv_we = 1'b1; iv_wdata = 128'hDEAD;
        @(negedge clk);
        cfg_we = 1'b0; iv_we = 1'b0;
        chk("R6 iv held", iv_rd, iv_m);
        chk("R6 err untouched", 128'(cfg_err), 128'(1'b0));
        chk("R6 still running", 128'(run_o), 128'(1'b1));
        feed(pt, 16, res);
        chk("R6 output uses held iv", res, expect_out(iv_m, pt, 16));
        chk("R6 counter from held iv", iv_rd, step(iv_m));

        // non-counter chaining refused
        s0 = starts;
        write_cfg(1'b1, 3'b000, 2'b00);
        chk("R1 refused run", 128'(run_o), 128'(1'b0));
        repeat (2) @(negedge clk);
        chk("R1 no start", 128'(starts), 128'(s0));
        chk("R1 no error", 128'(cfg_err), 128'(1'b0));

        // forbidden mode in counter chaining
        write_cfg(1'b1, 3'b010, 2'b01);
        chk("R7 refused run", 128'(run_o), 128'(1'b0));
        chk("R7 err set", 128'(cfg_err), 128'(1'b1));
        repeat (2) @(negedge clk);
        chk("R7 no start", 128'(starts), 128'(s0));
        iv_m = iv_rd;
        run_block(iv_m, 2'b10, pt, 16, res);
        chk("R7 err sticky", 128'(cfg_err), 128'(1'b1));

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule